// File: doc/BRIEF.md
# Counter-Mode DRBG Request and Reseed Scheduler

This block sequences the work of a counter-mode deterministic random bit generator around an external block-cipher core. Software-side one-shot commands (instantiate, reseed, update, generate) enter as single-cycle pulses. Each command is latched as pending, and the scheduler serves pending commands one at a time. Instantiate, reseed and update each become a single request pulse to the core. The scheduler then waits for the core's operation-done handshake.

A generate command expands into a series of 128-bit block strobes. The series length is 2^E − 4, where E is the configured length exponent after clamping. Only one block is outstanding at a time, and the next strobe waits for the core's block-done handshake. The scheduler counts generate requests against a programmable interval, also clamped. Once the interval is used up, the next generate is preceded by a reseed that the scheduler raises itself. Instantiate and every reseed clear the count.

Top module: `drbg_req_sched`

## Requirements
- R1: While reset is asserted, and in the first cycles after release with no command, all request outputs (blkStrobe, instReq, reseedReq, updReq, reqDone) are low.
- R2: For a length exponent E with 4 ≤ E ≤ 12, one generate command produces exactly 2^E − 4 block strobes (E=4 gives 12, E=5 gives 28).
- R3: A length exponent outside 4..12 (for example 3 or 15) is treated as 12, so a generate produces 4092 block strobes.
- R4: Every block strobe is a one-cycle pulse, and a new strobe is issued only after blkDone has answered the previous one.
- R5: reqDone pulses for exactly one cycle, and it is high in the cycle right after the blkDone that answers the last block of a request.
- R6: Once the number of generate requests since the last instantiate or reseed equals the effective interval, the next generate first raises reseedReq and waits for opDone, and only then issues its block strobes (interval 2: the third generate reseeds; interval 1: every generate after the first reseeds).
- R7: An interval value of 0, or one above 2^25, is treated as 2^25, so a few consecutive generates cause no automatic reseed.
- R8: Instantiate and reseed commands, and automatic reseeds, reset the request count to zero.
- R9: Commands that arrive while a request is in progress are held pending and then served in the order instantiate, reseed, update, generate, whatever order they arrived in.
- R10: Each instantiate, reseed or update command produces exactly one one-cycle pulse on its own request output. At most one of the four request outputs is high in any cycle, and no new request is issued until the core's opDone completes the previous one.
- R11: An update command does not reset the request count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLenExp | input | 4 | Request length exponent E (blocks = 2^E − 4, clamped) |
| cfgInterval | input | 26 | Maximum generate requests between reseeds (clamped) |
| cmdInst | input | 1 | Instantiate command pulse |
| cmdReseed | input | 1 | Reseed command pulse |
| cmdUpdate | input | 1 | Update command pulse |
| cmdGen | input | 1 | Generate command pulse |
| blkDone | input | 1 | Core has finished the outstanding 128-bit block |
| opDone | input | 1 | Core has finished the outstanding instantiate/reseed/update |
| blkStrobe | output | 1 | Start one 128-bit block generation |
| instReq | output | 1 | Start instantiate in the core |
| reseedReq | output | 1 | Start reseed in the core (software or automatic) |
| updReq | output | 1 | Start update in the core |
| reqDone | output | 1 | Generate request complete pulse |

## Verification
The checker watches every cycle for the handshake rules. Strobes are single pulses and never overlap an unanswered block, request outputs are mutually exclusive, and an operation request cannot be followed directly by another request. reqDone must always follow a blkDone. Some behaviour depends on configuration held over a whole request, or on history across many requests, and only the directed scenarios can show it. That covers the exact block count per exponent and the clamping of bad exponents and intervals. It also covers when an automatic reseed is inserted, which commands clear the request count, and the service order of commands collected while a generate runs.

// File: rtl/drbg_sched_pkg.sv
package drbg_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPREQ,
    ST_OPWAIT,
    ST_STRB,
    ST_BWAIT,
    ST_DONE
  } schedState_t;

  typedef enum logic [1:0] {
    OP_INST,
    OP_RESEED,
    OP_UPDATE
  } schedOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBlocks;
    logic decBlock;
    logic bumpCount;
    logic clearCount;
  } dpCtl_t;

endpackage

// File: rtl/drbg_sched_dpath.sv
module drbg_sched_dpath
  import drbg_sched_pkg::*;
#(
  parameter int EXP_W   = 4,
  parameter int EXP_MIN = 4,
  parameter int EXP_MAX = 12,
  parameter int INT_W   = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [EXP_W-1:0] cfgLenExp,
  input  logic [INT_W-1:0] cfgInterval,
  input  dpCtl_t           dpCtl,
  output logic             lastBlock,
  output logic             intervalHit
);

  localparam int BLK_W = EXP_MAX;
  localparam logic [INT_W-1:0] INT_MAX = {1'b1, {(INT_W-1){1'b0}}};

  logic [EXP_W-1:0] effExp;
  logic [BLK_W:0]   powVal;
  logic [BLK_W-1:0] blockTotal;
  logic [BLK_W-1:0] blocksLeft;
  logic [INT_W-1:0] effInterval;
  logic [INT_W-1:0] reqCount;

  // exponent clamp: anything outside the legal window selects the maximum
  always_comb begin
    if ((int'(cfgLenExp) < EXP_MIN) || (int'(cfgLenExp) > EXP_MAX))
      effExp = EXP_W'(EXP_MAX);
    else
      effExp = cfgLenExp;
    powVal     = (BLK_W+1)'(1) << effExp;
    blockTotal = BLK_W'(powVal - (BLK_W+1)'(4));
  end

  // interval clamp: zero or above the ceiling selects the ceiling
  always_comb begin
    if ((cfgInterval == '0) || (cfgInterval > INT_MAX))
      effInterval = INT_MAX;
    else
      effInterval = cfgInterval;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blocksLeft <= '0;
    end else if (dpCtl.loadBlocks) begin
      blocksLeft <= blockTotal;
    end else if (dpCtl.decBlock && (blocksLeft != '0)) begin
      blocksLeft <= blocksLeft - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqCount <= '0;
    end else if (dpCtl.clearCount) begin
      reqCount <= '0;
    end else if (dpCtl.bumpCount && (reqCount != '1)) begin
      reqCount <= reqCount + 1'b1;
    end
  end

  assign lastBlock   = (blocksLeft == BLK_W'(1));
  assign intervalHit = (reqCount >= effInterval);

endmodule

// File: rtl/drbg_sched_ctrl.sv
module drbg_sched_ctrl
  import drbg_sched_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cmdInst,
  input  logic   cmdReseed,
  input  logic   cmdUpdate,
  input  logic   cmdGen,
  input  logic   blkDone,
  input  logic   opDone,
  input  logic   lastBlock,
  input  logic   intervalHit,
  output dpCtl_t dpCtl,
  output logic   blkStrobe,
  output logic   instReq,
  output logic   reseedReq,
  output logic   updReq,
  output logic   reqDone
);

  schedState_t state, stateNext;
  schedOp_t    curOp, curOpNext;

  logic pendInst, pendReseed, pendUpd, pendGen;
  logic takeInst, takeReseed, takeUpd, takeGen;

  // a command arriving in the cycle its pending flag is consumed stays pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendInst   <= 1'b0;
      pendReseed <= 1'b0;
      pendUpd    <= 1'b0;
      pendGen    <= 1'b0;
    end else begin
      pendInst   <= cmdInst   | (pendInst   & ~takeInst);
      pendReseed <= cmdReseed | (pendReseed & ~takeReseed);
      pendUpd    <= cmdUpdate | (pendUpd    & ~takeUpd);
      pendGen    <= cmdGen    | (pendGen    & ~takeGen);
    end
  end

  always_comb begin
    stateNext  = state;
    curOpNext  = curOp;
    takeInst   = 1'b0;
    takeReseed = 1'b0;
    takeUpd    = 1'b0;
    takeGen    = 1'b0;
    dpCtl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (pendInst) begin
          takeInst  = 1'b1;
          curOpNext = OP_INST;
          stateNext = ST_OPREQ;
        end else if (pendReseed) begin
          takeReseed = 1'b1;
          curOpNext  = OP_RESEED;
          stateNext  = ST_OPREQ;
        end else if (pendUpd) begin
          takeUpd   = 1'b1;
          curOpNext = OP_UPDATE;
          stateNext = ST_OPREQ;
        end else if (pendGen) begin
          if (intervalHit) begin
            // forced reseed; the generate stays pending behind it
            curOpNext = OP_RESEED;
            stateNext = ST_OPREQ;
          end else begin
            takeGen          = 1'b1;
            dpCtl.loadBlocks = 1'b1;
            dpCtl.bumpCount  = 1'b1;
            stateNext        = ST_STRB;
          end
        end
      end
      ST_OPREQ: stateNext = ST_OPWAIT;
      ST_OPWAIT: begin
        if (opDone) begin
          dpCtl.clearCount = (curOp != OP_UPDATE);
          stateNext        = ST_IDLE;
        end
      end
      ST_STRB: stateNext = ST_BWAIT;
      ST_BWAIT: begin
        if (blkDone) begin
          dpCtl.decBlock = 1'b1;
          stateNext      = lastBlock ? ST_DONE : ST_STRB;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curOp <= OP_INST;
    end else begin
      state <= stateNext;
      curOp <= curOpNext;
    end
  end

  assign blkStrobe = (state == ST_STRB);
  assign reqDone   = (state == ST_DONE);
  assign instReq   = (state == ST_OPREQ) && (curOp == OP_INST);
  assign reseedReq = (state == ST_OPREQ) && (curOp == OP_RESEED);
  assign updReq    = (state == ST_OPREQ) && (curOp == OP_UPDATE);

endmodule

// File: rtl/drbg_req_sched.sv
module drbg_req_sched
  import drbg_sched_pkg::*;
#(
  parameter int EXP_W   = 4,
  parameter int EXP_MIN = 4,
  parameter int EXP_MAX = 12,
  parameter int INT_W   = 26
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [EXP_W-1:0] cfgLenExp,
  input  logic [INT_W-1:0] cfgInterval,
  input  logic             cmdInst,
  input  logic             cmdReseed,
  input  logic             cmdUpdate,
  input  logic             cmdGen,
  input  logic             blkDone,
  input  logic             opDone,
  output logic             blkStrobe,
  output logic             instReq,
  output logic             reseedReq,
  output logic             updReq,
  output logic             reqDone
);

  dpCtl_t dpCtl;
  logic   lastBlock;
  logic   intervalHit;

  drbg_sched_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdInst    (cmdInst),
    .cmdReseed  (cmdReseed),
    .cmdUpdate  (cmdUpdate),
    .cmdGen     (cmdGen),
    .blkDone    (blkDone),
    .opDone     (opDone),
    .lastBlock  (lastBlock),
    .intervalHit(intervalHit),
    .dpCtl      (dpCtl),
    .blkStrobe  (blkStrobe),
    .instReq    (instReq),
    .reseedReq  (reseedReq),
    .updReq     (updReq),
    .reqDone    (reqDone)
  );

  drbg_sched_dpath #(
    .EXP_W  (EXP_W),
    .EXP_MIN(EXP_MIN),
    .EXP_MAX(EXP_MAX),
    .INT_W  (INT_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgLenExp  (cfgLenExp),
    .cfgInterval(cfgInterval),
    .dpCtl      (dpCtl),
    .lastBlock  (lastBlock),
    .intervalHit(intervalHit)
  );

endmodule

// File: rtl/drbg_req_sched_chk.sv
module drbg_req_sched_chk (
  input logic clk,
  input logic rstN,
  input logic blkDone,
  input logic blkStrobe,
  input logic instReq,
  input logic reseedReq,
  input logic updReq,
  input logic reqDone
);

  logic blkOutstanding;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          blkOutstanding <= 1'b0;
    else if (blkStrobe) blkOutstanding <= 1'b1;
    else if (blkDone)   blkOutstanding <= 1'b0;
  end

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkStrobe |=> !blkStrobe);

  // R4
  strobe_answered_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkStrobe |-> !blkOutstanding);

  // R5
  done_follows_blk_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> $past(blkDone));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  // R10
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({blkStrobe, instReq, reseedReq, updReq}));

  // R10
  op_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instReq || reseedReq || updReq) |=> !(instReq || reseedReq || updReq || blkStrobe));

endmodule

bind drbg_req_sched drbg_req_sched_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .blkDone  (blkDone),
  .blkStrobe(blkStrobe),
  .instReq  (instReq),
  .reseedReq(reseedReq),
  .updReq   (updReq),
  .reqDone  (reqDone)
);

// File: tb/drbg_req_sched_bench.sv
module drbg_req_sched_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cfgLenExp = 4'd4;
  logic [25:0] cfgInterval = 26'd0;
  logic        cmdInst = 1'b0, cmdReseed = 1'b0, cmdUpdate = 1'b0, cmdGen = 1'b0;
  logic        blkDone = 1'b0, opDone = 1'b0;
  logic        blkStrobe, instReq, reseedReq, updReq, reqDone;

  always #5 clk = ~clk;

  drbg_req_sched u_drbg_req_sched (
    .clk(clk), .rstN(rstN), .cfgLenExp(cfgLenExp), .cfgInterval(cfgInterval),
    .cmdInst(cmdInst), .cmdReseed(cmdReseed), .cmdUpdate(cmdUpdate), .cmdGen(cmdGen),
    .blkDone(blkDone), .opDone(opDone), .blkStrobe(blkStrobe), .instReq(instReq),
    .reseedReq(reseedReq), .updReq(updReq), .reqDone(reqDone)
  );

  int nChecks = 0, nFails = 0;
  int cyc = 0;
  int strobeCnt = 0, instCnt = 0, rsdCnt = 0, updCnt = 0, doneCnt = 0, opDoneCnt = 0;
  int lastBlkCyc = 0, doneCyc = 0;
  int bWait = 0, oWait = 0;
  bit inGen = 1'b0;
  int logBuf[32];
  int logN = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void logPush(input int code);
    if (logN < 32) begin
      logBuf[logN] = code;
      logN++;
    end
  endfunction

  // core model: answers each strobe or operation request two cycles later
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      blkDone = 1'b0;
      opDone  = 1'b0;
      if (bWait > 0) begin
        bWait--;
        if (bWait == 0) begin blkDone = 1'b1; lastBlkCyc = cyc; end
      end
      if (oWait > 0) begin
        oWait--;
        if (oWait == 0) begin opDone = 1'b1; opDoneCnt++; end
      end
      if (blkStrobe) begin
        strobeCnt++;
        bWait = 2;
        if (!inGen) begin logPush(4); inGen = 1'b1; end
      end
      if (instReq)   begin instCnt++; logPush(1); oWait = 2; end
      if (reseedReq) begin rsdCnt++;  logPush(2); oWait = 2; end
      if (updReq)    begin updCnt++;  logPush(3); oWait = 2; end
      if (reqDone)   begin doneCnt++; doneCyc = cyc; inGen = 1'b0; end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic runGen();
    int d0;
    d0 = doneCnt;
    cmdGen = 1'b1;
    tick(1);
    cmdGen = 1'b0;
    while (doneCnt == d0) tick(1);
    tick(2);
  endtask

  // which: 1 instantiate, 2 reseed, 3 update
  task automatic runCmd(input int which);
    int o0;
    o0 = opDoneCnt;
    cmdInst   = (which == 1);
    cmdReseed = (which == 2);
    cmdUpdate = (which == 3);
    tick(1);
    cmdInst = 1'b0; cmdReseed = 1'b0; cmdUpdate = 1'b0;
    while (opDoneCnt == o0) tick(1);
    tick(2);
  endtask

  task automatic tReset();
    tick(1);
    check(!(blkStrobe | instReq | reseedReq | updReq | reqDone), "R1", "outputs in reset",
          {blkStrobe, instReq, reseedReq, updReq, reqDone}, 0);
    rstN = 1'b1;
    tick(3);
    check(!(blkStrobe | instReq | reseedReq | updReq | reqDone), "R1", "outputs after reset",
          {blkStrobe, instReq, reseedReq, updReq, reqDone}, 0);
  endtask

  task automatic tLength(input int e, input int expBlocks, input string req);
    int s0;
    cfgLenExp = 4'(e);
    s0 = strobeCnt;
    runGen();
    check(strobeCnt - s0 == expBlocks, req, $sformatf("blocks for exponent %0d", e),
          strobeCnt - s0, expBlocks);
    // R5 timing of completion
    check(doneCyc == lastBlkCyc + 1, "R5", "reqDone cycle after last blkDone",
          doneCyc, lastBlkCyc + 1);
  endtask

  task automatic tCommandPulses();
    int i0, r0, u0;
    i0 = instCnt; r0 = rsdCnt; u0 = updCnt;
    runCmd(1);
    check(instCnt - i0 == 1 && rsdCnt == r0 && updCnt == u0, "R10", "instantiate pulses",
          instCnt - i0, 1);
    runCmd(2);
    check(rsdCnt - r0 == 1 && instCnt - i0 == 1, "R10", "reseed pulses", rsdCnt - r0, 1);
    runCmd(3);
    check(updCnt - u0 == 1 && rsdCnt - r0 == 1, "R10", "update pulses", updCnt - u0, 1);
  endtask

  task automatic tAutoReseed();
    int r0, s0;
    cfgLenExp = 4'd4;
    cfgInterval = 26'd2;
    runCmd(1);
    r0 = rsdCnt;
    runGen();
    runGen();
    check(rsdCnt == r0, "R6", "no reseed within interval", rsdCnt - r0, 0);
    logN = 0;
    s0 = strobeCnt;
    runGen();
    check(rsdCnt - r0 == 1, "R6", "forced reseed on third request", rsdCnt - r0, 1);
    check(logN == 2 && logBuf[0] == 2 && logBuf[1] == 4, "R6", "reseed precedes blocks",
          logBuf[0], 2);
    check(strobeCnt - s0 == 12, "R6", "blocks after forced reseed", strobeCnt - s0, 12);
    // interval 1: every generate after the first reseeds
    cfgInterval = 26'd1;
    runCmd(1);
    r0 = rsdCnt;
    runGen(); runGen(); runGen();
    check(rsdCnt - r0 == 2, "R6", "interval one reseeds", rsdCnt - r0, 2);
  endtask

  task automatic tIntervalClamp();
    int r0;
    cfgLenExp = 4'd4;
    cfgInterval = 26'd0;
    runCmd(1);
    r0 = rsdCnt;
    for (int k = 0; k < 4; k++) runGen();
    check(rsdCnt == r0, "R7", "interval zero clamps high", rsdCnt - r0, 0);
    cfgInterval = 26'd33554437;
    for (int k = 0; k < 3; k++) runGen();
    check(rsdCnt == r0, "R7", "interval above ceiling clamps", rsdCnt - r0, 0);
  endtask

  task automatic tCountReset();
    int r0;
    cfgLenExp = 4'd4;
    cfgInterval = 26'd2;
    runCmd(1);
    r0 = rsdCnt;
    runGen(); runGen();
    runCmd(2);
    runGen(); runGen();
    check(rsdCnt - r0 == 1, "R8", "manual reseed clears count", rsdCnt - r0, 1);
    runCmd(1);
    runGen(); runGen();
    check(rsdCnt - r0 == 1, "R8", "instantiate clears count", rsdCnt - r0, 1);
    runCmd(3);
    runGen();
    check(rsdCnt - r0 == 2, "R11", "update keeps count", rsdCnt - r0, 2);
  endtask

  task automatic tPriority();
    int d0, o0;
    cfgLenExp = 4'd5;
    cfgInterval = 26'd0;
    logN = 0;
    d0 = doneCnt;
    o0 = opDoneCnt;
    cmdGen = 1'b1; tick(1); cmdGen = 1'b0;
    tick(6);
    cmdUpdate = 1'b1; tick(1); cmdUpdate = 1'b0;
    cmdReseed = 1'b1; tick(1); cmdReseed = 1'b0;
    cmdInst   = 1'b1; tick(1); cmdInst   = 1'b0;
    cmdGen    = 1'b1; tick(1); cmdGen    = 1'b0;
    check(doneCnt == d0 && instCnt >= 0 && logN == 1, "R9", "commands held during request",
          logN, 1);
    while (doneCnt < d0 + 2 || opDoneCnt < o0 + 3) tick(1);
    tick(2);
    check(logN == 5, "R9", "served command count", logN, 5);
    check(logBuf[1] == 1, "R9", "first served is instantiate", logBuf[1], 1);
    check(logBuf[2] == 2, "R9", "second served is reseed", logBuf[2], 2);
    check(logBuf[3] == 3, "R9", "third served is update", logBuf[3], 3);
    check(logBuf[4] == 4, "R9", "last served is generate", logBuf[4], 4);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    tReset();
    tCommandPulses();
    tLength(4, 12, "R2");
    tLength(5, 28, "R2");
    tLength(3, 4092, "R3");
    tLength(15, 4092, "R3");
    tAutoReseed();
    tIntervalClamp();
    tCountReset();
    tPriority();
    finishRun();
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190000);
    finishRun();
  end

endmodule